// File: doc/BRIEF.md
# Open-Drain Two-Wire Byte-Write Master with Bus Recovery

This block is a two-wire serial bus master that only writes. Software-side logic gives it one command at a time, each a single-cycle pulse: open a transfer with a START, shift one byte out, close the transfer with a STOP, or run a bus clear. The block drives each wire only by pulling it to ground through an output-enable. A released wire goes high through the external pull-up. The block watches both wires through a synchronizer and a majority glitch filter. It tracks whether the bus is occupied. It also reports three sticky error flags: lost arbitration, missing acknowledge and failed recovery.

The bus clear is a separate command with no START and no address. It pulls and releases the clock line while ignoring a data line held low. This lets a slave that was interrupted mid-byte clock out the rest of its bits and let go of SDA. The clear stops as soon as SDA is seen high during a clock-high phase and then closes with a STOP. It gives up after nine pulses.

The clock period is the parameter `DIV` in system clocks. Each phase lasts `DIV/2` cycles and must be at least 6. A slave may stretch the clock: the high phase is timed only from the moment SCL is sensed high.

Top module: `i2c_wr_master`

## Requirements
- R1: Out of reset and whenever idle with no transfer open, both output-enables are 0, so both wires are released. `busy` is 0 and all three flags are 0.
- R2: A start command on an idle bus lets SDA fall while SCL is high, then pulls SCL low. `bus_busy` (1 = occupied) then reads 1.
- R3: A write command sends 9 SCL clocks: the 8 bits of `wr_data` MSB first, then a ninth clock with SDA released for the receiver's acknowledge (SDA low = ACK). SDA changes only while SCL is low.
- R4: After SCL is released, the high phase is counted only from the moment SCL is sensed high. Every SCL high pulse therefore lasts at least `DIV/2` cycles, even when a slave stretches the low phase.
- R5: Suppose SDA is sensed low during a clock-high phase of a data bit for which the master released SDA. Then `arb_lost` is set, both wires are released, and no further clock pulses follow.
- R6: An acknowledge bit sampled high sets `nack` and is followed by a STOP. `nack` stays set until `clr_flags` is pulsed.
- R7: A start command while `bus_busy` is 1 sets `arb_lost` and produces no wire activity.
- R8: Address 0x00 is sent and acknowledged exactly like any other byte.
- R9: A recover command pulses SCL without any START, even with SDA low. Once SDA is sensed high at the end of a high phase, it stops pulsing and issues a STOP (SCL pulled low, SDA pulled low, SCL released, SDA released). With SDA freed after the second pulse, the bus shows 3 pulses plus the STOP's clock rise.
- R10: If SDA is still low after the ninth recovery pulse, `rec_fail` is set and both wires are left released. The bus shows exactly 9 clock rises and no STOP.
- R11: A stop command lets SDA rise while SCL is high, and `bus_busy` then reads 0.
- R12: A one-cycle glitch on either wire is filtered out: a single-cycle low pulse on SDA while SCL is high does not set `bus_busy`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| go_start | input | 1 | Pulse: generate a START |
| go_write | input | 1 | Pulse: send `wr_data` and sample the acknowledge |
| go_stop | input | 1 | Pulse: generate a STOP |
| go_recover | input | 1 | Pulse: run the bus clear |
| wr_data | input | 8 | Byte to send, taken with `go_write` |
| clr_flags | input | 1 | Pulse: clear `arb_lost`, `nack`, `rec_fail` |
| scl_i | input | 1 | Sensed level of the SCL wire |
| sda_i | input | 1 | Sensed level of the SDA wire |
| scl_oe | output | 1 | 1 pulls SCL to ground |
| sda_oe | output | 1 | 1 pulls SDA to ground |
| busy | output | 1 | A command is in progress; commands are taken only while 0 |
| bus_busy | output | 1 | A START was seen and no STOP since |
| arb_lost | output | 1 | Sticky: arbitration lost or start refused |
| nack | output | 1 | Sticky: acknowledge missing |
| rec_fail | output | 1 | Sticky: bus clear did not free SDA |

## Verification
The bench targets a slave holding SDA low across a released data bit. A master that kept clocking there would corrupt the other driver's transfer, and one that stopped clocking without the flag would hang software. In the bus clear, the slave is freed partway through, and the bench counts clock rises. A design that obeyed normal arbitration would produce no pulses at all. One that overran would not show the early STOP, or would not stop at nine. A clock stretched by the slave, a refused START on an occupied bus and a one-cycle SDA glitch cover, in turn, high phases timed from the release instead of the sensed level, a START that disturbs the bus, and a false START detection.

// File: rtl/i2c_wr_pkg.sv
package i2c_wr_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_ST_SETUP,
    S_ST_HOLD,
    S_LOW,
    S_HWAIT,
    S_HIGH,
    S_SP_LOW,
    S_SP_HWAIT,
    S_SP_HIGH,
    S_SP_FREE
  } eng_state_t;

  localparam int unsigned LAST_CLOCK = 8;

endpackage

// File: rtl/i2c_glitch_filter.sv
module i2c_glitch_filter #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);

  logic [SYNC-1:0] sync_q;
  logic [2:0]      win_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
      win_q  <= '1;
      dout   <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC-2:0], din};
      win_q  <= {win_q[1:0], sync_q[SYNC-1]};
      dout   <= (win_q[0] & win_q[1]) | (win_q[0] & win_q[2]) | (win_q[1] & win_q[2]);
    end
  end

endmodule

// File: rtl/i2c_bus_watch.sv
module i2c_bus_watch (
  input  logic clk,
  input  logic rst,
  input  logic scl_f,
  input  logic sda_f,
  output logic bus_busy
);

  logic scl_q, sda_q;
  logic saw_start, saw_stop;

  assign saw_start = scl_f && scl_q && sda_q && !sda_f;
  assign saw_stop  = scl_f && scl_q && !sda_q && sda_f;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
      bus_busy <= 1'b0;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
      if (saw_start)     bus_busy <= 1'b1;
      else if (saw_stop) bus_busy <= 1'b0;
    end
  end

endmodule

// File: rtl/i2c_wr_engine.sv
module i2c_wr_engine
  import i2c_wr_pkg::*;
#(
  parameter int HALF = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       go_start,
  input  logic       go_write,
  input  logic       go_stop,
  input  logic       go_recover,
  input  logic [7:0] wr_data,
  input  logic       clr_flags,
  input  logic       bus_busy,
  input  logic       scl_f,
  input  logic       sda_f,
  output logic       scl_oe,
  output logic       sda_oe,
  output logic       busy,
  output logic       arb_lost,
  output logic       nack,
  output logic       rec_fail
);

  localparam int CW = $clog2(HALF) + 1;
  localparam logic [CW-1:0] PH_END = CW'(HALF - 1);
  localparam logic [3:0]    LAST   = 4'(LAST_CLOCK);

  eng_state_t     st;
  logic [CW-1:0]  cnt;
  logic [3:0]     bit_idx;
  logic [7:0]     shreg;
  logic           rec;
  logic           ph_done;

  assign ph_done = (cnt == PH_END);
  assign busy    = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      cnt      <= '0;
      bit_idx  <= '0;
      shreg    <= '0;
      rec      <= 1'b0;
      scl_oe   <= 1'b0;
      sda_oe   <= 1'b0;
      arb_lost <= 1'b0;
      nack     <= 1'b0;
      rec_fail <= 1'b0;
    end else begin
      if (clr_flags) begin
        arb_lost <= 1'b0;
        nack     <= 1'b0;
        rec_fail <= 1'b0;
      end
      unique case (st)
        S_IDLE: begin
          cnt <= '0;
          if (go_recover) begin
            rec     <= 1'b1;
            bit_idx <= '0;
            sda_oe  <= 1'b0;
            scl_oe  <= 1'b1;
            st      <= S_LOW;
          end else if (go_start) begin
            if (bus_busy) arb_lost <= 1'b1;
            else begin
              scl_oe <= 1'b0;
              sda_oe <= 1'b0;
              st     <= S_ST_SETUP;
            end
          end else if (go_write) begin
            rec     <= 1'b0;
            shreg   <= wr_data;
            bit_idx <= '0;
            scl_oe  <= 1'b1;
            st      <= S_LOW;
          end else if (go_stop) begin
            scl_oe <= 1'b1;
            st     <= S_SP_LOW;
          end
        end
        S_ST_SETUP: begin
          if (scl_f) begin
            cnt <= cnt + 1'b1;
            if (ph_done) begin
              cnt    <= '0;
              sda_oe <= 1'b1;
              st     <= S_ST_HOLD;
            end
          end
        end
        S_ST_HOLD: begin
          cnt <= cnt + 1'b1;
          if (ph_done) begin
            cnt    <= '0;
            scl_oe <= 1'b1;
            st     <= S_IDLE;
          end
        end
        S_LOW: begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(1) && !rec) sda_oe <= (bit_idx == LAST) ? 1'b0 : !shreg[7];
          if (ph_done) begin
            cnt    <= '0;
            scl_oe <= 1'b0;
            st     <= S_HWAIT;
          end
        end
        S_HWAIT: begin
          cnt <= '0;
          if (scl_f) st <= S_HIGH;
        end
        S_HIGH: begin
          cnt <= cnt + 1'b1;
          if (!rec && bit_idx != LAST && !sda_oe && !sda_f) begin
            arb_lost <= 1'b1;
            scl_oe   <= 1'b0;
            sda_oe   <= 1'b0;
            st       <= S_IDLE;
          end else if (ph_done) begin
            cnt <= '0;
            if (rec) begin
              if (sda_f) begin
                scl_oe <= 1'b1;
                st     <= S_SP_LOW;
              end else if (bit_idx == LAST) begin
                rec_fail <= 1'b1;
                st       <= S_IDLE;
              end else begin
                bit_idx <= bit_idx + 1'b1;
                scl_oe  <= 1'b1;
                st      <= S_LOW;
              end
            end else if (bit_idx == LAST) begin
              scl_oe <= 1'b1;
              if (sda_f) begin
                nack <= 1'b1;
                st   <= S_SP_LOW;
              end else begin
                st <= S_IDLE;
              end
            end else begin
              shreg   <= {shreg[6:0], 1'b0};
              bit_idx <= bit_idx + 1'b1;
              scl_oe  <= 1'b1;
              st      <= S_LOW;
            end
          end
        end
        S_SP_LOW: begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(1)) sda_oe <= 1'b1;
          if (ph_done) begin
            cnt    <= '0;
            scl_oe <= 1'b0;
            st     <= S_SP_HWAIT;
          end
        end
        S_SP_HWAIT: begin
          cnt <= '0;
          if (scl_f) st <= S_SP_HIGH;
        end
        S_SP_HIGH: begin
          cnt <= cnt + 1'b1;
          if (ph_done) begin
            cnt    <= '0;
            sda_oe <= 1'b0;
            st     <= S_SP_FREE;
          end
        end
        S_SP_FREE: begin
          cnt <= cnt + 1'b1;
          if (ph_done) begin
            cnt <= '0;
            st  <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R3: SDA is held steady for the whole clock-high phase
  assert_sda_steady_high_R3: assert property (@(posedge clk) disable iff (rst)
    (st == S_HIGH && $past(st) == S_HIGH) |-> $stable(sda_oe));

  // R4: the high phase only starts once SCL is sensed high
  assert_wait_sensed_high_R4: assert property (@(posedge clk) disable iff (rst)
    (st == S_HWAIT && !scl_f) |=> (st == S_HWAIT));

  // R5: losing arbitration releases both wires at once
  assert_arb_release_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(arb_lost) && !$past(go_start) |-> (!scl_oe && !sda_oe && st == S_IDLE));

  // R6: a missing acknowledge leads into the STOP sequence
  assert_nack_stop_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(nack) |-> (st == S_SP_LOW));

  // R10: failed recovery leaves both wires released
  assert_recover_fail_release_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(rec_fail) |-> (!scl_oe && !sda_oe));

  // R9: never more than nine clocks per byte or recovery
  assert_clock_limit_R9: assert property (@(posedge clk) disable iff (rst)
    bit_idx <= LAST);

endmodule

// File: rtl/i2c_wr_master.sv
module i2c_wr_master #(
  parameter int DIV  = 20,
  parameter int SYNC = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       go_start,
  input  logic       go_write,
  input  logic       go_stop,
  input  logic       go_recover,
  input  logic [7:0] wr_data,
  input  logic       clr_flags,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe,
  output logic       sda_oe,
  output logic       busy,
  output logic       bus_busy,
  output logic       arb_lost,
  output logic       nack,
  output logic       rec_fail
);

  localparam int HALF  = DIV / 2;
  localparam int LINES = 2;

  logic [LINES-1:0] raw_lines;
  logic [LINES-1:0] filt_lines;

  assign raw_lines = {sda_i, scl_i};

  for (genvar g = 0; g < LINES; g++) begin : g_filt
    i2c_glitch_filter #(.SYNC(SYNC)) u_filt (
      .clk (clk),
      .rst (rst),
      .din (raw_lines[g]),
      .dout(filt_lines[g])
    );
  end

  i2c_bus_watch u_watch (
    .clk     (clk),
    .rst     (rst),
    .scl_f   (filt_lines[0]),
    .sda_f   (filt_lines[1]),
    .bus_busy(bus_busy)
  );

  i2c_wr_engine #(.HALF(HALF)) u_eng (
    .clk       (clk),
    .rst       (rst),
    .go_start  (go_start),
    .go_write  (go_write),
    .go_stop   (go_stop),
    .go_recover(go_recover),
    .wr_data   (wr_data),
    .clr_flags (clr_flags),
    .bus_busy  (bus_busy),
    .scl_f     (filt_lines[0]),
    .sda_f     (filt_lines[1]),
    .scl_oe    (scl_oe),
    .sda_oe    (sda_oe),
    .busy      (busy),
    .arb_lost  (arb_lost),
    .nack      (nack),
    .rec_fail  (rec_fail)
  );

  // R7: a START requested on an occupied bus is refused with arb_lost
  assert_start_refused_R7: assert property (@(posedge clk) disable iff (rst)
    (go_start && !go_recover && !busy && bus_busy) |=> (arb_lost && !busy));

endmodule

// File: tb/test_i2c_wr_master.sv
module test_i2c_wr_master;

  localparam int DIV  = 20;
  localparam int HALF = DIV / 2;
  localparam int K_START = 1, K_BYTE = 2, K_STOP = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic go_start = 0, go_write = 0, go_stop = 0, go_recover = 0, clr_flags = 0;
  logic [7:0] wr_data = 8'h00;
  logic scl_oe, sda_oe, busy, bus_busy, arb_lost, nack, rec_fail;

  logic slv_scl = 0, slv_hold = 0, glitch_sda = 0;
  logic slv_ack = 0;
  logic mon_en = 0, ack_en = 1;
  logic stuck_on = 0;
  int   stuck_base = 0, stuck_n = 0;
  int   fall_cnt = 0, rise_cnt = 0, stop_cnt = 0;
  logic slv_stuck;
  logic scl_line, sda_line;

  assign slv_stuck = stuck_on && ((fall_cnt - stuck_base) < stuck_n);
  assign scl_line  = !(scl_oe || slv_scl);
  assign sda_line  = !(sda_oe || slv_ack || slv_hold || slv_stuck || glitch_sda);

  always #2 clk = ~clk;

  i2c_wr_master #(.DIV(DIV)) i_i2c_wr_master (
    .clk(clk), .rst(rst), .go_start(go_start), .go_write(go_write),
    .go_stop(go_stop), .go_recover(go_recover), .wr_data(wr_data),
    .clr_flags(clr_flags), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy), .bus_busy(bus_busy),
    .arb_lost(arb_lost), .nack(nack), .rec_fail(rec_fail)
  );

  // scoreboard: {kind, ack, byte}
  logic [10:0] exp_q[$];
  int checks = 0, fails = 0;
  int sb_checks = 0, sb_fails = 0;
  int wd_fail = 0;
  logic done = 0;

  task automatic push(input int kind, input logic ack, input logic [7:0] b);
    exp_q.push_back({2'(kind), ack, b});
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // bus monitor, slave acknowledge and pulse counters
  logic p_scl = 1, p_sda = 1;
  int   bits = 0;
  logic [7:0] sh = 0;
  logic ackb = 0;
  longint t_rise = 0;

  task automatic observe(input logic [10:0] got);
    logic [10:0] want;
    sb_checks++;
    if (exp_q.size() == 0) begin
      sb_fails++;
      $display("FAIL R3 scoreboard: actual %0h expected none", got);
    end else begin
      want = exp_q.pop_front();
      if (got !== want) begin
        sb_fails++;
        $display("FAIL R3/R8 scoreboard: actual %0h expected %0h", got, want);
      end
    end
  endtask

  always @(scl_line, sda_line) begin
    if (sda_line !== p_sda && scl_line && p_scl) begin
      if (!sda_line) begin
        if (mon_en) begin bits = 0; observe({2'(K_START), 1'b0, 8'h00}); end
      end else begin
        stop_cnt++;
        if (mon_en) begin bits = 0; observe({2'(K_STOP), 1'b0, 8'h00}); end
      end
    end
    if (scl_line && !p_scl) begin
      rise_cnt++;
      t_rise = $time;
      if (mon_en) begin
        if (bits < 8) sh = {sh[6:0], sda_line};
        else ackb = sda_line;
        bits++;
        if (bits == 9) begin
          bits = 0;
          observe({2'(K_BYTE), ackb, sh});
        end
      end
    end
    if (!scl_line && p_scl) begin
      fall_cnt++;
      if (mon_en && t_rise != 0) begin
        sb_checks++;
        if (($time - t_rise) / 4 < HALF) begin
          sb_fails++;
          $display("FAIL R4 high width: actual %0d expected >= %0d", ($time - t_rise) / 4, HALF);
        end
      end
      slv_ack <= (mon_en && ack_en && bits == 8);
    end
    p_scl = scl_line;
    p_sda = sda_line;
  end

  task automatic pulse(input int op, input logic [7:0] d);
    @(negedge clk);
    wr_data = d;
    case (op)
      0: go_start = 1;
      1: go_write = 1;
      2: go_stop = 1;
      3: go_recover = 1;
      default: clr_flags = 1;
    endcase
    @(negedge clk);
    go_start = 0; go_write = 0; go_stop = 0; go_recover = 0; clr_flags = 0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    repeat (12) @(negedge clk);
  endtask

  task automatic report();
    int tot, bad;
    tot = checks + sb_checks + wd_fail;
    bad = fails + sb_fails + wd_fail;
    $display("%0d/%0d checks passed", tot - bad, tot);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      wd_fail = 1;
      $display("FAIL watchdog: actual hung expected done");
      report();
    end
  end

  initial begin
    int fc, rc, sc;
    repeat (5) @(negedge clk);
    rst = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 scl_oe", scl_oe, 0);
    check("R1 sda_oe", sda_oe, 0);
    check("R1 busy", busy, 0);
    check("R1 flags", {arb_lost, nack, rec_fail}, 0);

    // R12 one-cycle SDA glitch while SCL high
    glitch_sda = 1; @(negedge clk); glitch_sda = 0;
    repeat (20) @(negedge clk);
    check("R12 glitch ignored", bus_busy, 0);

    // R2, R3, R8, R4, R11 normal transfer
    mon_en = 1; ack_en = 1;
    push(K_START, 0, 8'h00);
    pulse(0, 8'h00); wait_idle();
    check("R2 bus_busy after start", bus_busy, 1);
    check("R2 scl held low", scl_line, 0);
    push(K_BYTE, 0, 8'h00);
    pulse(1, 8'h00); wait_idle();                       // R8 general call
    push(K_BYTE, 0, 8'hA5);
    pulse(1, 8'hA5); wait_idle();
    push(K_BYTE, 0, 8'h3C);
    pulse(1, 8'h3C);                                    // R4 stretched clock
    repeat (3) @(negedge scl_line);
    #1 slv_scl = 1;
    repeat (30) @(negedge clk);
    slv_scl = 0;
    wait_idle();
    push(K_BYTE, 0, 8'hFF);
    pulse(1, 8'hFF); wait_idle();
    check("R1 no nack on ack", nack, 0);
    push(K_STOP, 0, 8'h00);
    pulse(2, 8'h00); wait_idle();
    check("R11 bus_busy after stop", bus_busy, 0);
    check("R1 idle lines", {scl_line, sda_line}, 2'b11);

    // R6 NACK
    push(K_START, 0, 8'h00);
    pulse(0, 8'h00); wait_idle();
    ack_en = 0;
    push(K_BYTE, 1, 8'h5A);
    push(K_STOP, 0, 8'h00);
    pulse(1, 8'h5A); wait_idle();
    check("R6 nack set", nack, 1);
    check("R6 stop after nack", bus_busy, 0);
    repeat (50) @(negedge clk);
    check("R6 nack sticky", nack, 1);
    pulse(4, 8'h00);
    check("R6 nack cleared", nack, 0);
    ack_en = 1;

    // R7 START refused on occupied bus
    push(K_START, 0, 8'h00);
    pulse(0, 8'h00); wait_idle();
    fc = fall_cnt; rc = rise_cnt;
    pulse(0, 8'h00);
    @(negedge clk);
    check("R7 arb_lost on busy start", arb_lost, 1);
    check("R7 no command taken", busy, 0);
    repeat (40) @(negedge clk);
    check("R7 no wire activity", {fall_cnt - fc, rise_cnt - rc}, 0);
    push(K_STOP, 0, 8'h00);
    pulse(2, 8'h00); wait_idle();
    pulse(4, 8'h00);

    // R5 arbitration lost on a released bit
    push(K_START, 0, 8'h00);
    pulse(0, 8'h00); wait_idle();
    mon_en = 0;
    slv_hold = 1;
    pulse(1, 8'h85);
    while (busy) @(negedge clk);
    check("R5 arb_lost", arb_lost, 1);
    @(negedge clk);
    check("R5 scl released", scl_line, 1);
    fc = fall_cnt;
    repeat (100) @(negedge clk);
    check("R5 no more clocks", fall_cnt - fc, 0);
    slv_hold = 0;
    repeat (20) @(negedge clk);
    check("R5 bus freed by other driver", bus_busy, 0);
    pulse(4, 8'h00);

    // R9 recovery, slave frees SDA after three falling edges
    stuck_base = fall_cnt; stuck_n = 3; stuck_on = 1;
    repeat (20) @(negedge clk);
    rc = rise_cnt; sc = stop_cnt;
    pulse(3, 8'h00); wait_idle();
    check("R9 rec_fail clear", rec_fail, 0);
    check("R9 clock rises", rise_cnt - rc, 4);
    check("R9 stop issued", stop_cnt - sc, 1);
    check("R9 lines high", {scl_line, sda_line}, 2'b11);
    check("R9 bus_busy clear", bus_busy, 0);
    stuck_on = 0;

    // R10 recovery with SDA stuck for good
    stuck_base = fall_cnt; stuck_n = 1000; stuck_on = 1;
    repeat (20) @(negedge clk);
    rc = rise_cnt; sc = stop_cnt;
    pulse(3, 8'h00); wait_idle();
    check("R10 rec_fail set", rec_fail, 1);
    check("R10 nine pulses", rise_cnt - rc, 9);
    check("R10 no stop", stop_cnt - sc, 0);
    check("R10 wires released", {scl_oe, sda_oe}, 0);
    stuck_on = 0;
    repeat (20) @(negedge clk);
    pulse(4, 8'h00);
    check("R10 flag cleared", rec_fail, 0);

    check("R3 all expected bus items seen", exp_q.size(), 0);
    done = 1;
    report();
  end

endmodule